// File: doc/BRIEF.md
# Interrupt Flag and Enable Combiner

This block gathers the interrupt sources of a timekeeping unit (a periodic tick, an alarm match and an update-ended event) and turns them into one shared, active-low, open-drain request line. Each source arrives as a single-cycle event pulse. The pulse sets a latched status flag whether or not that source is enabled, so software can also poll. A control register holds one enable bit per source. The request line is pulled low while at least one flag is set together with its enable. When no enabled flag is pending, the line is released, so several devices can share one pulled-up wire.

Software sees two registers on a simple strobe bus. The control register holds the enables and can be read and written. The status register is read-only and clears on read. A status read returns a summary request bit and the three flags, then clears every flag on that clock edge. A flag whose event pulse arrives in the same cycle as the clearing read stays set, so the event is not lost. The active-low reset clears only the enables and the flags. It never touches the time or memory state held outside this block. The pin is modelled as a pull-low enable, `irq_pull_o`.

Top module: `irq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises, all flags and enables are zero, irq_pull_o is 0, and both registers read as zero.
- R2: An event pulse on evt_i[i] (bit 0 periodic, bit 1 alarm, bit 2 update) sets flag i at the next clock edge, whether or not enable i is set.
- R3: irq_pull_o is 1 exactly when some flag i and its enable i are both set. It can only rise after an event pulse or a control write.
- R4: A status read (reg_sel_i = 1, reg_rd_i = 1) returns bit 7 = summary request (same value as irq_pull_o), bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag, bits 3..0 = 0.
- R5: A status read clears all flags at that clock edge, so irq_pull_o is 0 afterwards unless a new event arrived.
- R6: An event pulse in the same cycle as a status read leaves that flag set after the edge.
- R7: A control write (reg_sel_i = 0, reg_wr_i = 1) loads enables from reg_wdata_i bits 6 (periodic), 5 (alarm) and 4 (update). Other bits are ignored. A control read returns the enables at the same positions, with all other bits 0.
- R8: A write to the status register has no effect on the flags or the enables.
- R9: A control read does not clear any flag.
- R10: reg_rdata_o is zero in any cycle where reg_rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of enables and flags |
| evt_i | input | 3 | Single-cycle event pulses: 0 periodic, 1 alarm, 2 update |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid while reg_rd_i is high |
| irq_pull_o | output | 1 | Pull-low enable for the open-drain request line |

## Verification
The embedded assertions check every cycle that an event pulse sets its flag, that a same-cycle event survives a clearing read, and that a status read without events releases the line. They also check that enables follow control writes, that status writes leave state unchanged, and that the request never rises without an event or a control write. Only the bench scenarios can show the exact bit layout of both read words, and that the line follows every combination of flags and enables. They also show the asynchronous reset arriving mid-operation, and long random mixes of reads, writes and events compared against an independent model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned N_SRC   = 3;
  localparam int unsigned SUM_BIT = DATA_W - 1;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic rd_stat;
    logic rd_ctrl;
    logic wr_ctrl;
    logic wr_stat;
  } bus_strb_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pkg::*;
(
  input  logic      sel_i,
  input  logic      rd_i,
  input  logic      wr_i,
  output bus_strb_t strb_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  always_comb begin
    strb_o.rd_stat = rd_i && (sel == SEL_STAT);
    strb_o.rd_ctrl = rd_i && (sel == SEL_CTRL);
    strb_o.wr_ctrl = wr_i && (sel == SEL_CTRL);
    strb_o.wr_stat = wr_i && (sel == SEL_STAT);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_i,
  output logic [N_SRC-1:0] flag_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    logic flag_q;
    // event wins over clear so a coincident pulse is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (evt_i[i]) flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;

    p_evt_sets_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_o[i]);
    p_evt_beats_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[i] && clr_i) |=> flag_o[i]);
    p_clear_drops_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !evt_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  en_o
);
  localparam int unsigned SRC_MSB = DATA_W - 2;

  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] en_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_pick
    assign en_d[i] = wdata_i[SRC_MSB-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end
  assign en_o = en_q;

  p_en_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_o == $past(en_d)));
  p_en_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_SRC-1:0]  flag_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic              rd_stat_i,
  input  logic              rd_ctrl_i,
  output logic              req_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SUM_BIT = DATA_W - 1;
  localparam int unsigned SRC_MSB = DATA_W - 2;

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] ctrl_word;

  assign req_o = |(flag_i & en_i);

  always_comb begin
    stat_word = '0;
    ctrl_word = '0;
    stat_word[SUM_BIT] = req_o;
    for (int i = 0; i < int'(N_SRC); i++) begin
      stat_word[SRC_MSB-i] = flag_i[i];
      ctrl_word[SRC_MSB-i] = en_i[i];
    end
  end

  always_comb begin
    if (rd_stat_i)      rdata_o = stat_word;
    else if (rd_ctrl_i) rdata_o = ctrl_word;
    else                rdata_o = '0;
  end

  always_comb begin
    a_idle_zero_r10: assert (rd_stat_i || rd_ctrl_i || rdata_o == '0);
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NSRC  = N_SRC,
  parameter int unsigned DW    = DATA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            reg_sel_i,
  input  logic            reg_rd_i,
  input  logic            reg_wr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_pull_o
);
  bus_strb_t        strb;
  logic [NSRC-1:0]  flags;
  logic [NSRC-1:0]  enables;

  irq_bus_decode u_dec (
    .sel_i  (reg_sel_i),
    .rd_i   (reg_rd_i),
    .wr_i   (reg_wr_i),
    .strb_o (strb)
  );

  irq_flag_bank #(.N_SRC(NSRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (strb.rd_stat),
    .flag_o (flags)
  );

  irq_enable_reg #(.N_SRC(NSRC), .DATA_W(DW)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (strb.wr_ctrl),
    .wdata_i (reg_wdata_i),
    .en_o    (enables)
  );

  irq_combine #(.N_SRC(NSRC), .DATA_W(DW)) u_comb (
    .flag_i    (flags),
    .en_i      (enables),
    .rd_stat_i (strb.rd_stat),
    .rd_ctrl_i (strb.rd_ctrl),
    .req_o     (irq_pull_o),
    .rdata_o   (reg_rdata_o)
  );

  p_rise_has_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pull_o) |-> ($past(evt_i) != '0 || $past(strb.wr_ctrl)));
  p_read_releases_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb.rd_stat && evt_i == '0) |=> !irq_pull_o);
  p_stat_wr_inert_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb.wr_stat && evt_i == '0) |=> $stable(flags));
  p_ctrl_rd_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb.rd_ctrl && !reg_wr_i) |=> ((flags & $past(flags)) == $past(flags)));
  p_summary_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.rd_stat |-> (reg_rdata_o[DW-1] == irq_pull_o));
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt = '0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  bit [2:0] m_flag = '0;
  bit [2:0] m_en   = '0;

  always #2 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_sel_i(sel),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_pull_o(irq)
  );

  function automatic logic [7:0] pack(bit top, bit [2:0] v);
    logic [7:0] w = '0;
    w[7] = top;
    for (int i = 0; i < 3; i++) w[6-i] = v[i];
    return w;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit w, bit s, logic [7:0] wd, logic [2:0] e, string tag = "");
    bit sum;
    @(negedge clk);
    rd = r; wr = w; sel = s; wdata = wd; evt = e;
    #1;
    sum = |(m_flag & m_en);
    check("R3", {7'd0, irq}, {7'd0, sum});
    if (r)
      check(tag != "" ? tag : (s ? "R4" : "R7"), rdata,
            s ? pack(sum, m_flag) : pack(1'b0, m_en));
    else
      check("R10", rdata, 8'h00);
    @(posedge clk);
    if (w && !s) m_en = {wd[4], wd[5], wd[6]};
    if (r && s) m_flag = '0;
    m_flag |= e;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 8'h00, 3'b000);
  endtask

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1", {7'd0, irq}, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: registers read zero after reset
    step(1, 0, 1, 8'h00, 3'b000, "R1");
    step(1, 0, 0, 8'h00, 3'b000, "R1");

    // R2: events latch without enables, no request
    step(0, 0, 0, 8'h00, 3'b001);
    step(0, 0, 0, 8'h00, 3'b100);
    step(1, 0, 0, 8'h00, 3'b000, "R9");
    step(1, 0, 1, 8'h00, 3'b000, "R2");
    step(1, 0, 1, 8'h00, 3'b000, "R5");

    // R7: enable write with junk in other bits
    step(0, 1, 0, 8'hAF, 3'b000);
    step(1, 0, 0, 8'h00, 3'b000, "R7");
    step(0, 0, 0, 8'h00, 3'b010);
    step(0, 0, 0, 8'h00, 3'b000);      // R3 irq high
    step(1, 0, 1, 8'h00, 3'b000, "R4");
    step(0, 0, 0, 8'h00, 3'b000);      // R5 irq low after read
    step(1, 0, 1, 8'h00, 3'b000, "R5");

    // R6: event coincides with clearing read
    step(0, 1, 0, 8'h70, 3'b000);
    step(0, 0, 0, 8'h00, 3'b011);
    step(1, 0, 1, 8'h00, 3'b100);
    step(1, 0, 1, 8'h00, 3'b000, "R6");

    // R8: status write has no effect
    step(0, 0, 0, 8'h00, 3'b101);
    step(0, 1, 1, 8'h00, 3'b000);
    step(0, 1, 1, 8'hFF, 3'b000);
    step(1, 0, 0, 8'h00, 3'b000, "R8");
    step(1, 0, 1, 8'h00, 3'b000, "R8");

    // R3: each single enable against each flag
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, 8'h40 >> i, 3'b000);
      for (int j = 0; j < 3; j++) begin
        step(1, 0, 1, 8'h00, 3'b000);
        step(0, 0, 0, 8'h00, 3'(1 << j));
        step(0, 0, 0, 8'h00, 3'b000);
      end
    end

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int op = $urandom_range(0, 9);
      logic [2:0] e = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      case (op)
        0, 1:    step(1, 0, 1, 8'h00, e);
        2:       step(1, 0, 0, 8'h00, e);
        3:       step(0, 1, 0, 8'($urandom), e);
        4:       step(0, 1, 1, 8'($urandom), e, "R8");
        default: step(0, 0, 0, 8'h00, e);
      endcase
    end

    // R1: asynchronous reset mid-operation
    step(0, 1, 0, 8'h70, 3'b111);
    step(0, 0, 0, 8'h00, 3'b000);
    @(negedge clk);
    #1 rst_n = 1'b0;
    m_flag = '0; m_en = '0;
    #1 check("R1", {7'd0, irq}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    step(1, 0, 1, 8'h00, 3'b000, "R1");
    step(1, 0, 0, 8'h00, 3'b000, "R1");
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule